// File: doc/BRIEF.md
# Sixteen-Line Interrupting I/O Bank

This block is a bank of sixteen general-purpose I/O lines sitting behind a simple 32-bit register bus. For each line, software can drive an output value and pick a direction. It can also choose whether the processor or another on-chip owner drives the pad, and it can read back the line's synchronised input level. When a pin is handed to the processor, the bank's output and direction registers drive that pad. Otherwise the alternate owner's value and enable pass straight through.

Each input goes through a two-flop synchroniser. A per-line select chooses whether a rising edge or a falling edge is detected. A detected edge sets a sticky status bit whether or not the line is masked. Software clears status by writing ones to it. One registered bank interrupt is raised while any status bit is set on a line whose mask bit is clear.

Top module: `pio_bank`

## Requirements
- R1: After reset the mask register reads 0x0000FFFF (all lines masked). The direction register reads 0x0000FFFF (all inputs). Status, data output, edge select and pin control all read 0, and `bank_irq` is low.
- R2: Register byte offsets are: data input 0x00, data output 0x04, direction 0x08, edge select 0x0C, mask 0x10, status 0x14, pin control 0x18. A read request accepted at a clock edge presents its data on `bus_rdata` right after that edge. Unmapped offsets read 0, and writes to them have no effect.
- R3: The data input register returns `pad_in` after two synchroniser stages. A pin change made before edge e1 reads as the old value in a read captured at e2 and as the new value in a read captured at e3. Writes to the data input register are ignored.
- R4: A direction bit of 1 makes the line an input, so `pad_oe` is low for an owned pin. A direction bit of 0 makes the line an output and drives the data-output bit.
- R5: A pin-control bit of 1 hands the pad to the processor: `pad_out` = data output and `pad_oe` = NOT direction. With a 0 bit, `pad_out` = `alt_out` and `pad_oe` = `alt_oe`.
- R6: An edge-select bit of 1 detects rising edges and 0 detects falling edges; the opposite edge is ignored. A pin change made before edge e1 sets the status bit at e3.
- R7: A detected edge sets its status bit even while that line is masked.
- R8: Writing the status register clears each bit written as 1. Bits written as 0 are unchanged.
- R9: A status bit that receives a new edge in the same cycle as a clear write to it stays set.
- R10: `bank_irq` is a register that takes the OR over all lines of (status AND NOT mask). It therefore follows a status or mask change one clock later.
- R11: Only the low 16 bits of the mask (and of every other line register) are stored. The upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 16 | Raw pad input levels |
| pad_out | output | 16 | Pad output value |
| pad_oe | output | 16 | Pad output enable, active high |
| alt_out | input | 16 | Output value from the alternate pin owner |
| alt_oe | input | 16 | Output enable from the alternate pin owner |
| bank_irq | output | 1 | Combined bank interrupt |

## Verification
Each result has a fixed latency after its stimulus, and each check samples at that point:

- **Register reads:** the value appears one edge after the request.
- **Pads:** they follow register writes combinationally, right after the write edge.
- **Synchronised input:** a pin change becomes readable two edges after it is made. The bench checks that the read at the second edge still returns the old value and the read at the third returns the new one.
- **Status and interrupt:** status sets at the third edge and `bank_irq` rises at the fourth. The bench samples the interrupt on the falling edge after the third and after the fourth rising edge. After a clear or a mask change, it checks the interrupt both one and two edges later.
- **Same-cycle set and clear:** the clear write is placed so that it lands on the exact edge where the new edge sets the status bit.

// File: rtl/pio_bank_pkg.sv
package pio_bank_pkg;

   localparam logic [31:0] OFS_DIN  = 32'h00;
   localparam logic [31:0] OFS_DOUT = 32'h04;
   localparam logic [31:0] OFS_DIR  = 32'h08;
   localparam logic [31:0] OFS_EDGE = 32'h0C;
   localparam logic [31:0] OFS_MASK = 32'h10;
   localparam logic [31:0] OFS_STAT = 32'h14;
   localparam logic [31:0] OFS_OWN  = 32'h18;

   typedef enum logic [2:0] {
      SEL_DIN,
      SEL_DOUT,
      SEL_DIR,
      SEL_EDGE,
      SEL_MASK,
      SEL_STAT,
      SEL_OWN,
      SEL_NONE
   } reg_sel_e;

   function automatic reg_sel_e pio_decode(input logic [31:0] ofs);
      reg_sel_e s;
      case (ofs)
         OFS_DIN:  s = SEL_DIN;
         OFS_DOUT: s = SEL_DOUT;
         OFS_DIR:  s = SEL_DIR;
         OFS_EDGE: s = SEL_EDGE;
         OFS_MASK: s = SEL_MASK;
         OFS_STAT: s = SEL_STAT;
         OFS_OWN:  s = SEL_OWN;
         default:  s = SEL_NONE;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/pio_sync_edge.sv
module pio_sync_edge #(
   parameter int unsigned LINES  = 16,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] pin_i,
   input  logic [LINES-1:0] rise_sel_i,
   output logic [LINES-1:0] lvl_o,
   output logic [LINES-1:0] edge_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pio_sync_edge: STAGES must be at least 2");
   end
   if (LINES < 1) begin : g_bad_lines
      $error("pio_sync_edge: LINES must be at least 1");
   end

   for (genvar i = 0; i < LINES; i++) begin : g_line
      logic [STAGES-1:0] chain_q;
      logic              last_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
         end else begin
            chain_q <= {chain_q[STAGES-2:0], pin_i[i]};
            last_q  <= chain_q[STAGES-1];
         end
      end

      assign lvl_o[i]  = chain_q[STAGES-1];
      assign edge_o[i] = rise_sel_i[i] ? (chain_q[STAGES-1] & ~last_q)
                                       : (~chain_q[STAGES-1] & last_q);

      // R6: a reported edge matches the selected direction of the level change
      assert_edge_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (edge_o[i] && rise_sel_i[i]) |-> (lvl_o[i] && !$past(lvl_o[i])));
      assert_edge_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (edge_o[i] && !rise_sel_i[i]) |-> (!lvl_o[i] && $past(lvl_o[i])));
   end

endmodule

// File: rtl/pio_irq_stat.sv
module pio_irq_stat #(
   parameter int unsigned LINES = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] set_i,
   input  logic [LINES-1:0] clr_i,
   input  logic [LINES-1:0] mask_i,
   output logic [LINES-1:0] status_o,
   output logic             irq_o
);

   logic [LINES-1:0] status_q;
   logic             irq_q;
   logic [LINES-1:0] live;

   assign live = status_q & ~mask_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
         irq_q    <= 1'b0;
      end else begin
         status_q <= (status_q & ~clr_i) | set_i;
         irq_q    <= |live;
      end
   end

   assign status_o = status_q;
   assign irq_o    = irq_q;

   // R9: a new edge survives a simultaneous clear
   assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_i) |=> ((status_o & $past(set_i)) == $past(set_i)));
   // R8: written ones clear their bits
   assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|clr_i) |=> ((status_o & $past(clr_i & ~set_i)) == '0));
   // R10: no unmasked status means the interrupt is low next cycle
   assert_irq_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(status_o & ~mask_i)) |=> !irq_o);
   // R10: the interrupt only rises after an unmasked status bit
   assert_irq_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(|(status_o & ~mask_i)));

endmodule

// File: rtl/pio_regs.sv
module pio_regs
   import pio_bank_pkg::*;
#(
   parameter int unsigned LINES  = 16,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [LINES-1:0]  din_i,
   input  logic [LINES-1:0]  status_i,
   output logic [LINES-1:0]  dout_o,
   output logic [LINES-1:0]  dir_o,
   output logic [LINES-1:0]  rise_o,
   output logic [LINES-1:0]  mask_o,
   output logic [LINES-1:0]  own_o,
   output logic [LINES-1:0]  clr_o
);

   if (LINES > DATA_W) begin : g_bad_width
      $error("pio_regs: LINES must not exceed DATA_W");
   end
   if (ADDR_W < 5 || ADDR_W > 32) begin : g_bad_addr
      $error("pio_regs: ADDR_W must be between 5 and 32");
   end

   logic [31:0]      addr_ext;
   reg_sel_e         dec;
   logic             wr;
   logic             rd;
   logic [LINES-1:0] wbits;
   logic [LINES-1:0] rd_mux;

   logic [LINES-1:0] dout_q;
   logic [LINES-1:0] dir_q;
   logic [LINES-1:0] rise_q;
   logic [LINES-1:0] mask_q;
   logic [LINES-1:0] own_q;
   logic [DATA_W-1:0] rdata_q;

   assign addr_ext = 32'(bus_addr);
   assign dec      = pio_decode(addr_ext);
   assign wr       = bus_sel & bus_we;
   assign rd       = bus_sel & ~bus_we;
   assign wbits    = bus_wdata[LINES-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q <= '0;
         dir_q  <= '1;
         rise_q <= '0;
         mask_q <= '1;
         own_q  <= '0;
      end else if (wr) begin
         case (dec)
            SEL_DOUT: dout_q <= wbits;
            SEL_DIR:  dir_q  <= wbits;
            SEL_EDGE: rise_q <= wbits;
            SEL_MASK: mask_q <= wbits;
            SEL_OWN:  own_q  <= wbits;
            default:  ;
         endcase
      end
   end

   always_comb begin
      case (dec)
         SEL_DIN:  rd_mux = din_i;
         SEL_DOUT: rd_mux = dout_q;
         SEL_DIR:  rd_mux = dir_q;
         SEL_EDGE: rd_mux = rise_q;
         SEL_MASK: rd_mux = mask_q;
         SEL_STAT: rd_mux = status_i;
         SEL_OWN:  rd_mux = own_q;
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (rd) begin
         rdata_q <= DATA_W'(rd_mux);
      end
   end

   assign clr_o     = (wr && dec == SEL_STAT) ? wbits : '0;
   assign bus_rdata = rdata_q;
   assign dout_o    = dout_q;
   assign dir_o     = dir_q;
   assign rise_o    = rise_q;
   assign mask_o    = mask_q;
   assign own_o     = own_q;

   // R1: while reset is held the lines come up masked and as inputs
   assert_reset_mask_R1: assert property (@(posedge clk)
      !rst_n |=> (mask_o == '1 && dir_o == '1 && own_o == '0));
   // R2: a register that is not written keeps its value
   assert_mask_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && dec == SEL_MASK) |=> $stable(mask_o));

endmodule

// File: rtl/pio_bank.sv
module pio_bank #(
   parameter int unsigned LINES       = 16,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [LINES-1:0]  pad_in,
   output logic [LINES-1:0]  pad_out,
   output logic [LINES-1:0]  pad_oe,
   input  logic [LINES-1:0]  alt_out,
   input  logic [LINES-1:0]  alt_oe,
   output logic              bank_irq
);

   logic [LINES-1:0] lvl;
   logic [LINES-1:0] edge_hit;
   logic [LINES-1:0] status;
   logic [LINES-1:0] dout;
   logic [LINES-1:0] dir;
   logic [LINES-1:0] rise;
   logic [LINES-1:0] mask;
   logic [LINES-1:0] own;
   logic [LINES-1:0] clr;

   pio_sync_edge #(.LINES(LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_i      (pad_in),
      .rise_sel_i (rise),
      .lvl_o      (lvl),
      .edge_o     (edge_hit)
   );

   pio_regs #(.LINES(LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .din_i     (lvl),
      .status_i  (status),
      .dout_o    (dout),
      .dir_o     (dir),
      .rise_o    (rise),
      .mask_o    (mask),
      .own_o     (own),
      .clr_o     (clr)
   );

   pio_irq_stat #(.LINES(LINES)) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (edge_hit),
      .clr_i    (clr),
      .mask_i   (mask),
      .status_o (status),
      .irq_o    (bank_irq)
   );

   for (genvar i = 0; i < LINES; i++) begin : g_pad
      assign pad_out[i] = own[i] ? dout[i] : alt_out[i];
      assign pad_oe[i]  = own[i] ? ~dir[i] : alt_oe[i];
   end

endmodule

// File: tb/pio_bank_tb_top.sv
module pio_bank_tb_top;
   import pio_bank_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [15:0] pad_in = '0;
   logic [15:0] pad_out;
   logic [15:0] pad_oe;
   logic [15:0] alt_out = 16'h1234;
   logic [15:0] alt_oe = 16'h5A5A;
   logic        bank_irq;

   int n_tests = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pio_bank dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pad_in    (pad_in),
      .pad_out   (pad_out),
      .pad_oe    (pad_oe),
      .alt_out   (alt_out),
      .alt_oe    (alt_oe),
      .bank_irq  (bank_irq)
   );

   typedef struct packed {
      logic [7:0]  ofs;
      logic [31:0] wval;
      logic [31:0] rexp;
   } vec_t;

   localparam int NVEC = 7;
   localparam vec_t VECS [NVEC] = '{
      '{8'h04, 32'hFFFF_A5A5, 32'h0000_A5A5},
      '{8'h08, 32'h0000_0F0F, 32'h0000_0F0F},
      '{8'h0C, 32'h0000_3C3C, 32'h0000_3C3C},
      '{8'h10, 32'hABCD_1234, 32'h0000_1234},
      '{8'h18, 32'h0000_00FF, 32'h0000_00FF},
      '{8'h00, 32'h0000_FFFF, 32'h0000_0000},
      '{8'h1C, 32'hFFFF_FFFF, 32'h0000_0000}
   };

   task automatic chk(input string req, input string what,
                      input logic [31:0] got, input logic [31:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   // caller stands at a falling edge; returns at the next falling edge
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b0;
      d = bus_rdata;
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      logic [31:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state, R5 unowned pads pass alternate owner
      rd(8'h10, r); chk("R1", "mask reset", r, 32'h0000_FFFF);
      rd(8'h14, r); chk("R1", "status reset", r, 32'h0);
      rd(8'h08, r); chk("R1", "dir reset", r, 32'h0000_FFFF);
      rd(8'h04, r); chk("R1", "dout reset", r, 32'h0);
      rd(8'h0C, r); chk("R1", "edge reset", r, 32'h0);
      rd(8'h18, r); chk("R1", "own reset", r, 32'h0);
      chk("R1", "irq reset", {31'b0, bank_irq}, 32'h0);
      chk("R5", "pad_out unowned", {16'b0, pad_out}, 32'h1234);
      chk("R5", "pad_oe unowned", {16'b0, pad_oe}, 32'h5A5A);

      // R2 R3 R11 register table
      for (int k = 0; k < NVEC; k++) begin
         wr(VECS[k].ofs, VECS[k].wval);
         rd(VECS[k].ofs, r);
         chk("R2", $sformatf("table ofs %h", VECS[k].ofs), r, VECS[k].rexp);
      end

      // R4 R5 pad mixing: own=00FF dir=0F0F dout=A5A5
      chk("R5", "pad_out mixed", {16'b0, pad_out}, 32'h12A5);
      chk("R4", "pad_oe mixed", {16'b0, pad_oe}, 32'h5AF0);

      // R3 synchroniser latency
      pad_in = 16'hC3A5;
      rd(8'h00, r);
      rd(8'h00, r); chk("R3", "din at second edge", r, 32'h0);
      rd(8'h00, r); chk("R3", "din at third edge", r, 32'h0000_C3A5);
      pad_in = 16'h0000;
      repeat (5) step();
      wr(8'h10, 32'h0000_FFFF);
      wr(8'h14, 32'h0000_FFFF);
      wr(8'h0C, 32'h0000_0001);
      repeat (2) step();
      rd(8'h14, r); chk("R8", "status cleared", r, 32'h0);
      chk("R10", "irq idle", {31'b0, bank_irq}, 32'h0);

      // R6 rising on line 0, line 1 on falling select ignores the rise
      wr(8'h10, 32'hFFFF_FFFE);
      pad_in = 16'h0003;
      repeat (3) step();
      chk("R10", "irq after third edge", {31'b0, bank_irq}, 32'h0);
      step();
      chk("R10", "irq after fourth edge", {31'b0, bank_irq}, 32'h1);
      rd(8'h14, r); chk("R6", "rise only line0", r, 32'h0000_0001);

      // R7 falling on masked line 1 still sets status
      pad_in = 16'h0000;
      repeat (4) step();
      rd(8'h14, r); chk("R7", "masked line latched", r, 32'h0000_0003);

      // R8 clear line 0; R10 irq drops one edge later
      wr(8'h14, 32'h0000_0001);
      chk("R10", "irq right after clear", {31'b0, bank_irq}, 32'h1);
      step();
      chk("R10", "irq one edge after clear", {31'b0, bank_irq}, 32'h0);
      rd(8'h14, r); chk("R8", "selective clear", r, 32'h0000_0002);

      // R10 unmask line 1
      wr(8'h10, 32'h0000_FFFC);
      chk("R10", "irq right after unmask", {31'b0, bank_irq}, 32'h0);
      step();
      chk("R10", "irq one edge after unmask", {31'b0, bank_irq}, 32'h1);

      // R9 clear lands on the same edge as a new status set
      wr(8'h0C, 32'h0000_0005);
      pad_in = 16'h0004;
      step();
      step();
      wr(8'h14, 32'h0000_0006);
      rd(8'h14, r); chk("R9", "set beats clear", r, 32'h0000_0004);

      // R8 writing zeros leaves status alone
      wr(8'h14, 32'h0000_0000);
      rd(8'h14, r); chk("R8", "zero write no effect", r, 32'h0000_0004);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule